// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block derives two clocks from one reference. The reference is either an on-chip oscillator clock or an external clock, chosen by a select bit, and a glitch-free multiplexer switches between them. The first stage divides the selected reference to make the data clock. The second stage divides the data clock to make a slower system clock, which paces memory accesses.

The first stage accepts every integer ratio from 1 to 16, and also 1.5 and 2.5. The second stage accepts integer ratios only. For integer ratios the high time of each output can be programmed in whole input cycles. Otherwise it defaults to half the period, and this holds for odd ratios too. Each stage loads new settings only when its current frame ends, so a change never cuts a pulse short.

Top module: `twostage_clkdiv`

## Requirements
- R1: `src_ext_i`=0 selects `clk_int_i` and `src_ext_i`=1 selects `clk_ext_i`. After a switch the divided clocks follow the new reference, and during the switch the merged reference shows no high phase shorter than the shorter high phase of the two inputs.
- R2: With `n_code_i[4]`=0, the low four bits k give a data clock period of k+1 reference periods, for k from 0 to 15.
- R3: With `n_code_i[4]`=1, bit 0 chooses a half ratio. Bit 0 = 0 gives a period of 1.5 reference periods that is high for one reference half-period. Bit 0 = 1 gives a period of 2.5 reference periods that is high for two reference half-periods.
- R4: `m_code_i`=k gives a system clock period of k+1 data clock periods, so the system clock period is always a whole number of data clock periods.
- R5: While `rst_i` is high, both clocks keep running at the default ratios whatever the setting inputs are. The default data clock equals the reference (ratio 1), and the default system clock period is two data clock periods.
- R6: An integer ratio N with duty code 0 gives a high time of N input half-periods (50%), which includes odd N.
- R7: A duty code d with 1 <= d < N gives a high time of d input cycles. A code d >= N falls back to 50%. The duty code has no effect at ratio 1 or at either half ratio.
- R8: New ratio and duty settings take effect only at a frame boundary of the stage. Every period and high time seen around a change belongs wholly to either the old setting or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int_i | input | 1 | on-chip oscillator reference clock |
| clk_ext_i | input | 1 | external reference clock |
| rst_i | input | 1 | synchronous active-high reset; forces the default ratios |
| src_ext_i | input | 1 | reference select: 0 internal, 1 external |
| n_code_i | input | 5 | first-stage ratio: bit 4 selects half ratios, bits 3:0 the integer ratio minus one |
| n_duty_i | input | 4 | first-stage high time in reference cycles; 0 means 50% |
| m_code_i | input | 4 | second-stage ratio minus one |
| m_duty_i | input | 4 | second-stage high time in data clock cycles; 0 means 50% |
| dclk_o | output | 1 | data clock (first-stage output) |
| sysclk_o | output | 1 | system clock (second-stage output) |

## Verification
Two functions can meet on the same reference edge: a frame reaching its last count, and a settings change arriving in that frame. The bench forces this by changing the first-stage ratio and duty part way through a long frame. It then records every data clock period and high time across the change and accepts each pulse only if it matches the old setting exactly or the new one exactly. A source switch at a ratio of 1 is judged the same way, by the shortest high phase recorded while the multiplexer hands over.

// File: rtl/ckdiv_pkg.sv
`timescale 1ps/1ps
package ckdiv_pkg;

  // Kind of division a stage performs in its current frame.
  typedef enum logic [1:0] {
    RK_INT          = 2'd0,
    RK_THREE_HALVES = 2'd1,
    RK_FIVE_HALVES  = 2'd2
  } ratio_kind_e;

  // Half-ratio patterns, counted in input half-periods.
  // A frame covers two output periods, so it lasts a whole number of input cycles.
  localparam int THREE_HALVES_SPAN  = 3;
  localparam int THREE_HALVES_HIGH  = 1;
  localparam int THREE_HALVES_CYCLS = 3;
  localparam int FIVE_HALVES_SPAN   = 5;
  localparam int FIVE_HALVES_HIGH   = 2;
  localparam int FIVE_HALVES_CYCLS  = 5;

endpackage

// File: rtl/ckdiv_refmux.sv
`timescale 1ps/1ps
// Glitch-free two-input clock multiplexer. Each side enables itself on its own
// falling edge, and only after the other side has been seen disabled.
module ckdiv_refmux (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_b_i,
  output logic clk_o
);

  logic a_sync_q, a_en_q;
  logic b_sync_q, b_en_q;

  // The chains have no reset: from power-up zero both sides are off, and the
  // selected side turns itself on within two of its own falling edges.
  always_ff @(negedge clk_a_i) begin
    a_sync_q <= ~sel_b_i & ~b_en_q;
    a_en_q   <= a_sync_q;
  end

  always_ff @(negedge clk_b_i) begin
    b_sync_q <= sel_b_i & ~a_en_q;
    b_en_q   <= b_sync_q;
  end

  assign clk_o = (clk_a_i & a_en_q) | (clk_b_i & b_en_q);

  // R1: the two enables, which come from separate clock domains, never overlap
  always_comb begin
    p_one_ref_r1: assert (!(a_en_q && b_en_q))
      else $error("both reference enables active");
  end

endmodule

// File: rtl/ckdiv_ratio_decode.sv
`timescale 1ps/1ps
// Turns a ratio code and a duty code into the frame parameters of a stage:
// last count of the frame (in input cycles), output period and high time
// (both in input half-periods).
module ckdiv_ratio_decode
  import ckdiv_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter bit HALF_EN = 1'b1,
  localparam int SLOT_W = RATIO_W + 2
) (
  input  logic [RATIO_W:0]   code_i,
  input  logic [RATIO_W-1:0] duty_i,
  output logic [RATIO_W-1:0] last_o,
  output logic [SLOT_W-1:0]  span_o,
  output logic [SLOT_W-1:0]  high_o
);

  ratio_kind_e      kind;
  logic [SLOT_W-1:0] n_ext;
  logic [SLOT_W-1:0] d_ext;

  always_comb begin
    n_ext = SLOT_W'(code_i[RATIO_W-1:0]) + SLOT_W'(1);
    d_ext = SLOT_W'(duty_i);
    if (HALF_EN && code_i[RATIO_W]) begin
      kind = code_i[0] ? RK_FIVE_HALVES : RK_THREE_HALVES;
    end else begin
      kind = RK_INT;
    end

    unique case (kind)
      RK_THREE_HALVES: begin
        last_o = RATIO_W'(THREE_HALVES_CYCLS - 1);
        span_o = SLOT_W'(THREE_HALVES_SPAN);
        high_o = SLOT_W'(THREE_HALVES_HIGH);
      end
      RK_FIVE_HALVES: begin
        last_o = RATIO_W'(FIVE_HALVES_CYCLS - 1);
        span_o = SLOT_W'(FIVE_HALVES_SPAN);
        high_o = SLOT_W'(FIVE_HALVES_HIGH);
      end
      default: begin
        last_o = code_i[RATIO_W-1:0];
        span_o = n_ext << 1;
        // programmed high time only when it leaves a low phase; else 50%
        if (d_ext != '0 && d_ext < n_ext) begin
          high_o = d_ext << 1;
        end else begin
          high_o = n_ext;
        end
      end
    endcase
  end

endmodule

// File: rtl/ckdiv_stage.sv
`timescale 1ps/1ps
// One divider stage. The frame is cut into input half-period slots. A
// rising-edge register and a falling-edge register together reproduce the
// wanted level of every slot through their XOR, which covers even, odd and
// half ratios with one datapath.
module ckdiv_stage #(
  parameter int              RATIO_W  = 4,
  parameter bit              HALF_EN  = 1'b1,
  parameter logic [RATIO_W:0] RST_CODE = '0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [RATIO_W:0]   code_i,
  input  logic [RATIO_W-1:0] duty_i,
  output logic               clk_o
);

  localparam int SLOT_W = RATIO_W + 2;

  // frame parameters from the live inputs and from the reset code
  logic [RATIO_W-1:0] live_last, rst_last;
  logic [SLOT_W-1:0]  live_span, rst_span;
  logic [SLOT_W-1:0]  live_high, rst_high;

  ckdiv_ratio_decode #(.RATIO_W(RATIO_W), .HALF_EN(HALF_EN)) dec_live_i (
    .code_i (code_i),
    .duty_i (duty_i),
    .last_o (live_last),
    .span_o (live_span),
    .high_o (live_high)
  );

  ckdiv_ratio_decode #(.RATIO_W(RATIO_W), .HALF_EN(HALF_EN)) dec_rst_i (
    .code_i (RST_CODE),
    .duty_i ('0),
    .last_o (rst_last),
    .span_o (rst_span),
    .high_o (rst_high)
  );

  // active frame parameters and cycle counter
  logic [RATIO_W-1:0] last_q, nxt_last;
  logic [SLOT_W-1:0]  span_q, nxt_span;
  logic [SLOT_W-1:0]  high_q, nxt_high;
  logic [RATIO_W-1:0] cnt_q, cnt_nxt;
  logic               rise_q, fall_q;

  always_comb begin
    if (rst_i) begin
      // keep counting so the clock stays alive under reset, at the defaults
      nxt_last = rst_last;
      nxt_span = rst_span;
      nxt_high = rst_high;
      cnt_nxt  = (cnt_q >= rst_last) ? '0 : cnt_q + 1'b1;
    end else if (cnt_q == last_q) begin
      // frame boundary: the only place new settings are accepted
      nxt_last = live_last;
      nxt_span = live_span;
      nxt_high = live_high;
      cnt_nxt  = '0;
    end else begin
      nxt_last = last_q;
      nxt_span = span_q;
      nxt_high = high_q;
      cnt_nxt  = cnt_q + 1'b1;
    end
  end

  function automatic logic slot_level(input logic [SLOT_W-1:0] slot,
                                      input logic [SLOT_W-1:0] span,
                                      input logic [SLOT_W-1:0] high);
    logic [SLOT_W-1:0] wrapped;
    // a half-ratio frame holds two output periods
    wrapped = (slot >= span) ? slot - span : slot;
    return wrapped < high;
  endfunction

  logic [SLOT_W-1:0] slot_even, slot_odd;
  assign slot_even = {1'b0, cnt_nxt, 1'b0};
  assign slot_odd  = {1'b0, cnt_q, 1'b1};

  always_ff @(posedge clk_i) begin
    cnt_q  <= cnt_nxt;
    last_q <= nxt_last;
    span_q <= nxt_span;
    high_q <= nxt_high;
    rise_q <= slot_level(slot_even, nxt_span, nxt_high) ^ fall_q;
  end

  always_ff @(negedge clk_i) begin
    fall_q <= slot_level(slot_odd, span_q, high_q) ^ rise_q;
  end

  assign clk_o = rise_q ^ fall_q;

  // R2: the counter never leaves the active frame
  p_cnt_in_frame_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= last_q)
    else $error("cycle counter beyond frame");

  // R8: settings move only together with a counter wrap to zero
  p_cfg_at_boundary_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0) |-> ($stable(last_q) && $stable(span_q) && $stable(high_q)))
    else $error("settings changed inside a frame");

  // R7: the high time always leaves a non-empty high and low phase
  p_high_inside_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (high_q != '0) && (high_q < span_q))
    else $error("high time outside the period");

  generate
    if (!HALF_EN) begin : g_int_only
      // R4: an integer-only stage always has an even number of half slots
      p_int_only_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        span_q[0] == 1'b0)
        else $error("half ratio in an integer-only stage");
    end
  endgenerate

endmodule

// File: rtl/twostage_clkdiv.sv
`timescale 1ps/1ps
module twostage_clkdiv #(
  parameter int RATIO_W    = 4,
  parameter int N_RST_CODE = 0,
  parameter int M_RST_CODE = 1
) (
  input  logic               clk_int_i,
  input  logic               clk_ext_i,
  input  logic               rst_i,
  input  logic               src_ext_i,
  input  logic [RATIO_W:0]   n_code_i,
  input  logic [RATIO_W-1:0] n_duty_i,
  input  logic [RATIO_W-1:0] m_code_i,
  input  logic [RATIO_W-1:0] m_duty_i,
  output logic               dclk_o,
  output logic               sysclk_o
);

  localparam logic [RATIO_W:0] N_RST = (RATIO_W + 1)'(N_RST_CODE);
  localparam logic [RATIO_W:0] M_RST = (RATIO_W + 1)'(M_RST_CODE);

  logic ref_clk;
  logic data_clk;

  ckdiv_refmux refmux_i (
    .clk_a_i (clk_int_i),
    .clk_b_i (clk_ext_i),
    .sel_b_i (src_ext_i),
    .clk_o   (ref_clk)
  );

  ckdiv_stage #(.RATIO_W(RATIO_W), .HALF_EN(1'b1), .RST_CODE(N_RST)) stage_n_i (
    .clk_i  (ref_clk),
    .rst_i  (rst_i),
    .code_i (n_code_i),
    .duty_i (n_duty_i),
    .clk_o  (data_clk)
  );

  ckdiv_stage #(.RATIO_W(RATIO_W), .HALF_EN(1'b0), .RST_CODE(M_RST)) stage_m_i (
    .clk_i  (data_clk),
    .rst_i  (rst_i),
    .code_i ({1'b0, m_code_i}),
    .duty_i (m_duty_i),
    .clk_o  (sysclk_o)
  );

  assign dclk_o = data_clk;

endmodule

// File: tb/twostage_clkdiv_tb_top.sv
`timescale 1ps/1ps
module twostage_clkdiv_tb_top;

  localparam int    INT_PERIOD_PS = 10000;
  localparam int    EXT_PERIOD_PS = 14000;
  localparam longint WATCHDOG_PS  = 64'd1500000000;

  logic       clk_int = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst     = 1'b1;
  logic       src     = 1'b0;
  logic [4:0] n_code  = '0;
  logic [3:0] n_duty  = '0;
  logic [3:0] m_code  = '0;
  logic [3:0] m_duty  = '0;
  logic       dclk, sclk;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  twostage_clkdiv dut_i (
    .clk_int_i (clk_int),
    .clk_ext_i (clk_ext),
    .rst_i     (rst),
    .src_ext_i (src),
    .n_code_i  (n_code),
    .n_duty_i  (n_duty),
    .m_code_i  (m_code),
    .m_duty_i  (m_duty),
    .dclk_o    (dclk),
    .sysclk_o  (sclk)
  );

  initial forever #(INT_PERIOD_PS / 2) clk_int = ~clk_int;
  initial forever #(EXT_PERIOD_PS / 2) clk_ext = ~clk_ext;

  // stimulus and expected values; expected times in half-periods of the chosen reference
  typedef struct packed {
    logic        src;
    logic [4:0]  nc;
    logic [3:0]  nd;
    logic [3:0]  mc;
    logic [3:0]  md;
    logic [15:0] dhi;
    logic [15:0] dper;
    logic [15:0] shi;
    logic [15:0] sper;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 5'd0,  4'd0, 4'd1,  4'd0, 16'd1,  16'd2,  16'd2,  16'd4},   // R2 R4 R6 ratio 1 / 2
    '{1'b0, 5'd2,  4'd0, 4'd2,  4'd0, 16'd3,  16'd6,  16'd9,  16'd18},  // R6 odd 3 / 3
    '{1'b1, 5'd3,  4'd1, 4'd0,  4'd0, 16'd2,  16'd8,  16'd2,  16'd8},   // R7 duty 1 of 4, R1 external
    '{1'b0, 5'd16, 4'd0, 4'd3,  4'd0, 16'd1,  16'd3,  16'd6,  16'd12},  // R3 1.5
    '{1'b1, 5'd17, 4'd0, 4'd1,  4'd0, 16'd2,  16'd5,  16'd5,  16'd10},  // R3 2.5
    '{1'b0, 5'd15, 4'd0, 4'd15, 4'd3, 16'd16, 16'd32, 16'd96, 16'd512}, // R2 R4 max ratios, R7 duty 3
    '{1'b0, 5'd4,  4'd7, 4'd4,  4'd2, 16'd5,  16'd10, 16'd20, 16'd50},  // R7 duty >= N falls back
    '{1'b1, 5'd6,  4'd0, 4'd0,  4'd5, 16'd7,  16'd14, 16'd7,  16'd14},  // R6 odd 7, R7 duty ignored at 1
    '{1'b0, 5'd16, 4'd3, 4'd2,  4'd1, 16'd1,  16'd3,  16'd3,  16'd9},   // R7 duty ignored at 1.5
    '{1'b1, 5'd1,  4'd1, 4'd6,  4'd0, 16'd2,  16'd4,  16'd14, 16'd28}   // R4 odd 7 over ratio 2
  };

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic meas_d(output longint hi, output longint per);
    longint t0, t1, t2;
    @(posedge dclk); t0 = $time;
    @(negedge dclk); t1 = $time;
    @(posedge dclk); t2 = $time;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic meas_s(output longint hi, output longint per);
    longint t0, t1, t2;
    @(posedge sclk); t0 = $time;
    @(negedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic settle();
    repeat (4) @(posedge sclk);
    repeat (2) @(posedge dclk);
    #3;
  endtask

  longint dh, dp, sh, sp;
  longint min_hi;
  longint win_hi [8];
  longint win_per [8];

  initial begin
    // R5: settings applied during reset must not matter
    n_code = 5'd5; n_duty = 4'd2; m_code = 4'd7; m_duty = 4'd1;
    repeat (40) @(posedge clk_int);
    meas_d(dh, dp);
    meas_s(sh, sp);
    check_eq("R5", "reset dclk high", dh, INT_PERIOD_PS / 2);
    check_eq("R5", "reset dclk period", dp, INT_PERIOD_PS);
    check_eq("R5", "reset sysclk high", sh, INT_PERIOD_PS);
    check_eq("R5", "reset sysclk period", sp, 2 * INT_PERIOD_PS);
    #3;
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NROWS; i++) begin
      longint hp;
      src    = ROWS[i].src;
      n_code = ROWS[i].nc;
      n_duty = ROWS[i].nd;
      m_code = ROWS[i].mc;
      m_duty = ROWS[i].md;
      hp = ROWS[i].src ? EXT_PERIOD_PS / 2 : INT_PERIOD_PS / 2;
      settle();
      meas_d(dh, dp);
      meas_s(sh, sp);
      check_eq("R2,R3,R6,R7", $sformatf("row %0d dclk high", i), dh, hp * longint'(ROWS[i].dhi));
      check_eq("R1,R2,R3", $sformatf("row %0d dclk period", i), dp, hp * longint'(ROWS[i].dper));
      check_eq("R4,R6,R7", $sformatf("row %0d sysclk high", i), sh, hp * longint'(ROWS[i].shi));
      check_eq("R4", $sformatf("row %0d sysclk period", i), sp, hp * longint'(ROWS[i].sper));
      #3;
    end

    // R8: change ratio and duty in the middle of a long frame
    src = 1'b0; n_code = 5'd4; n_duty = 4'd0; m_code = 4'd0; m_duty = 4'd0;
    settle();
    fork
      begin
        @(posedge dclk);
        #12003;
        n_code = 5'd2; n_duty = 4'd1;
      end
      begin
        for (int k = 0; k < 8; k++) meas_d(win_hi[k], win_per[k]);
      end
    join
    for (int k = 0; k < 8; k++) begin
      bit old_ok, new_ok;
      old_ok = (win_hi[k] == 25000) && (win_per[k] == 50000);
      new_ok = (win_hi[k] == 10000) && (win_per[k] == 30000);
      check_eq("R8", $sformatf("window pulse %0d is old or new (period)", k),
               (old_ok || new_ok) ? win_per[k] : -1, win_per[k]);
    end
    check_eq("R8", "last window period uses new setting", win_per[7], 30000);

    // R1: switch source at ratio 1 and look for short high phases
    #3;
    src = 1'b0; n_code = 5'd0; n_duty = 4'd0; m_code = 4'd0; m_duty = 4'd0;
    settle();
    min_hi = 64'd1000000;
    fork
      begin
        #(3 * INT_PERIOD_PS + 3);
        src = 1'b1;
      end
      begin
        for (int k = 0; k < 40; k++) begin
          longint t0;
          @(posedge dclk); t0 = $time;
          @(negedge dclk);
          if ($time - t0 < min_hi) min_hi = $time - t0;
        end
      end
    join
    check_eq("R1", "no short high phase during switch",
             (min_hi >= INT_PERIOD_PS / 2) ? 1 : 0, 1);
    settle();
    meas_d(dh, dp);
    check_eq("R1", "external period after switch", dp, EXT_PERIOD_PS);
    #3;
    src = 1'b0;
    settle();
    meas_d(dh, dp);
    check_eq("R1", "internal period after switch back", dp, INT_PERIOD_PS);

    // R5: reset again with non-default settings active
    #3;
    n_code = 5'd9; m_code = 4'd3;
    settle();
    #3;
    rst = 1'b1;
    repeat (60) @(posedge clk_int);
    meas_d(dh, dp);
    meas_s(sh, sp);
    check_eq("R5", "second reset dclk period", dp, INT_PERIOD_PS);
    check_eq("R5", "second reset sysclk period", sp, 2 * INT_PERIOD_PS);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(WATCHDOG_PS);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule